// File: doc/BRIEF.md
# Shared Memory Port with Narrow-Bus Width Adapter

The block places one 64-bit wide synchronous RAM behind two masters. One is an external processor bus whose data width is 16 or 32 bits and is chosen at run time by a single mode input. The other is an internal engine that always moves full 64-bit words with per-byte write enables. A two-way round-robin arbiter gives the single RAM port to one master per cycle. A lane adapter steers each narrow processor transfer into the correct halfword or doubleword of the 64-bit memory word.

On a processor write, only the addressed lane is written, through byte enables. On a processor read, the addressed lane is returned right-justified. The processor holds chip-select and a strobe until the block pulses `cpu_ready`. In 32-bit mode an access whose address bit 1 is set is misaligned. Such an access never reaches the memory, and it sets a sticky error flag.

Top module: `shram_width_arb`

## Requirements
- R1: After reset, `cpu_ready`, `cpu_err`, `eng_gnt` and `eng_rvalid` are low and `cpu_rdata` is zero.
- R2: With `cfg_wide`=1, a processor write changes only the 32-bit half selected by address bit 2 (0 = bits 31:0, 1 = bits 63:32) of the word at address bits [n+2:3]. A read returns that half.
- R3: With `cfg_wide`=0, a processor write changes only the halfword selected by address bits [2:1] (k selects bits 16k+15:16k). A read returns it in bits 15:0 with bits 31:16 zero.
- R4: An engine write updates only the bytes whose `eng_be` bit is set (bit b covers bits 8b+7:8b). An engine read is granted and then presents the 64-bit word with `eng_rvalid` high in the following cycle.
- R5: When both masters request in the same cycle, the master that was not granted most recently wins. After reset, the processor wins the first tie. Each grant lasts one cycle.
- R6: `cpu_ready` goes high one cycle after the processor's memory grant and stays high for exactly one cycle. Under contention, it comes at most two cycles after the request.
- R7: With `cfg_wide`=1 and address bit 1 set, a write leaves the memory unchanged and a read returns zero. `cpu_ready` is still pulsed one cycle after the request.
- R8: `cpu_err` rises on a misaligned access and stays high through later accesses until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | Processor width: 0 = 16-bit, 1 = 32-bit |
| cpu_cs | input | 1 | Processor chip-select, held until ready |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | CPU_AW | Halfword address (address bits 17:1) |
| cpu_wdata | input | 32 | Processor write data, right-justified |
| cpu_rdata | output | 32 | Processor read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Sticky misalignment flag |
| eng_req | input | 1 | Engine request, held until granted |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_addr | input | WORD_AW | Engine 64-bit word address |
| eng_be | input | 8 | Engine byte enables |
| eng_wdata | input | 64 | Engine write data |
| eng_gnt | output | 1 | Engine owns the memory port this cycle |
| eng_rvalid | output | 1 | Engine read data valid |
| eng_rdata | output | 64 | Engine read data |

## Verification
Arbitration and lane steering can both occur in one cycle: a narrow processor write can compete for the RAM port in the same cycle as an engine write to the same 64-bit word. The bench provokes this by starting both masters on the same clock edge, once after an engine-only access and once after a processor-only access. It then judges the grant order from the engine's wait and the processor's ready latency. A readback of the shared word confirms that neither master's bytes overwrote the other's.

// File: rtl/shram_pkg.sv
package shram_pkg;
  localparam int MEM_DW = 64;
  localparam int MEM_BE = MEM_DW / 8;

  // byte enables for a narrow lane; sel = address bits [2:1]
  function automatic logic [MEM_BE-1:0] lane_be(input logic wide, input logic [1:0] sel);
    if (wide) return sel[1] ? 8'hF0 : 8'h0F;
    return 8'h03 << {sel, 1'b0};
  endfunction

  // right-justified narrow lane taken out of a memory word
  function automatic logic [31:0] lane_pick(input logic [MEM_DW-1:0] w, input logic wide,
                                            input logic [1:0] sel);
    if (wide) return sel[1] ? w[63:32] : w[31:0];
    case (sel)
      2'd0:    return {16'h0, w[15:0]};
      2'd1:    return {16'h0, w[31:16]};
      2'd2:    return {16'h0, w[47:32]};
      default: return {16'h0, w[63:48]};
    endcase
  endfunction

  function automatic logic misaligned(input logic wide, input logic [1:0] sel);
    return wide & sel[0];
  endfunction
endpackage

// File: rtl/shram_rr_arb.sv
module shram_rr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  output logic gnt_a,
  output logic gnt_b
);
  logic last_a;

  assign gnt_a = req_a & (~req_b | ~last_a);
  assign gnt_b = req_b & ~gnt_a;

  always_ff @(posedge clk) begin
    if (!rst_n)              last_a <= 1'b0;
    else if (gnt_a || gnt_b) last_a <= gnt_a;
  end

  a_r5_tie_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    (req_a && req_b && last_a) |-> gnt_b);
  a_r5_tie_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (req_a && req_b && !last_a) |-> gnt_a);
  a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_a, gnt_b}));
endmodule

// File: rtl/shram_lane_adapt.sv
module shram_lane_adapt
  import shram_pkg::*;
(
  input  logic              wide,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata_n,
  output logic [MEM_BE-1:0] be,
  output logic [MEM_DW-1:0] wdata_w,
  output logic              misal,
  input  logic              rd_wide,
  input  logic [1:0]        rd_sel,
  input  logic [MEM_DW-1:0] rword,
  output logic [31:0]       rdata_n
);
  assign be      = lane_be(wide, sel);
  assign misal   = misaligned(wide, sel);
  assign wdata_w = wide ? {2{wdata_n}} : {4{wdata_n[15:0]}};
  assign rdata_n = lane_pick(rword, rd_wide, rd_sel);
endmodule

// File: rtl/shram_mem.sv
module shram_mem
  import shram_pkg::*;
#(
  parameter int WORD_AW = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WORD_AW-1:0] addr,
  input  logic [MEM_BE-1:0]  be,
  input  logic [MEM_DW-1:0]  wdata,
  output logic [MEM_DW-1:0]  rdata
);
  localparam int DEPTH = 1 << WORD_AW;
  logic [MEM_DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < MEM_BE; b++)
      if (we && be[b]) store[addr][8*b +: 8] <= wdata[8*b +: 8];
    rdata <= store[addr];
  end
endmodule

// File: rtl/shram_width_arb.sv
module shram_width_arb
  import shram_pkg::*;
#(
  parameter int CPU_AW  = 17,
  parameter int WORD_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wide,
  input  logic               cpu_cs,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_rdata,
  output logic               cpu_ready,
  output logic               cpu_err,
  input  logic               eng_req,
  input  logic               eng_we,
  input  logic [WORD_AW-1:0] eng_addr,
  input  logic [MEM_BE-1:0]  eng_be,
  input  logic [MEM_DW-1:0]  eng_wdata,
  output logic               eng_gnt,
  output logic               eng_rvalid,
  output logic [MEM_DW-1:0]  eng_rdata
);
  // named internal events
  logic              done_hold, cpu_pend, cpu_misal, cpu_mreq, cpu_gnt;
  logic [MEM_BE-1:0] cpu_be;
  logic [MEM_DW-1:0] cpu_wword, mem_dout, mem_wdata;
  logic [MEM_BE-1:0] mem_be;
  logic [WORD_AW-1:0] mem_addr;
  logic              mem_we;
  logic              rd_q, mis_q, wide_q, err_q, rv_q;
  logic [1:0]        sel_q, wait_cnt;
  logic [31:0]       lane_rd;

  assign cpu_pend = cpu_cs & (cpu_rd | cpu_wr) & ~done_hold;
  assign cpu_mreq = cpu_pend & ~cpu_misal;

  shram_lane_adapt u_lane (
    .wide(cfg_wide), .sel(cpu_addr[1:0]), .wdata_n(cpu_wdata),
    .be(cpu_be), .wdata_w(cpu_wword), .misal(cpu_misal),
    .rd_wide(wide_q), .rd_sel(sel_q), .rword(mem_dout), .rdata_n(lane_rd)
  );

  shram_rr_arb u_arb (
    .clk(clk), .rst_n(rst_n), .req_a(cpu_mreq), .req_b(eng_req),
    .gnt_a(cpu_gnt), .gnt_b(eng_gnt)
  );

  assign mem_addr  = cpu_gnt ? cpu_addr[WORD_AW+1:2] : eng_addr;
  assign mem_we    = cpu_gnt ? cpu_wr : (eng_gnt & eng_we);
  assign mem_be    = cpu_gnt ? cpu_be : eng_be;
  assign mem_wdata = cpu_gnt ? cpu_wword : eng_wdata;

  shram_mem #(.WORD_AW(WORD_AW)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .be(mem_be),
    .wdata(mem_wdata), .rdata(mem_dout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_hold <= 1'b0; cpu_ready <= 1'b0; rd_q <= 1'b0; mis_q <= 1'b0;
      wide_q <= 1'b0; sel_q <= 2'd0; err_q <= 1'b0; rv_q <= 1'b0; wait_cnt <= 2'd0;
    end else begin
      cpu_ready <= cpu_gnt | (cpu_pend & cpu_misal);
      rd_q      <= cpu_gnt & cpu_rd & ~cpu_wr;
      mis_q     <= cpu_pend & cpu_misal;
      rv_q      <= eng_gnt & ~eng_we;
      if (cpu_gnt) begin
        wide_q <= cfg_wide;
        sel_q  <= cpu_addr[1:0];
      end
      if (cpu_pend & cpu_misal) err_q <= 1'b1;
      if (!cpu_cs)                                done_hold <= 1'b0;
      else if (cpu_gnt || (cpu_pend && cpu_misal)) done_hold <= 1'b1;
      if (!cpu_pend)           wait_cnt <= 2'd0;
      else if (wait_cnt != 2'd3) wait_cnt <= wait_cnt + 2'd1;
    end
  end

  assign cpu_rdata  = (cpu_ready && rd_q && !mis_q) ? lane_rd : 32'h0;
  assign cpu_err    = err_q;
  assign eng_rvalid = rv_q;
  assign eng_rdata  = mem_dout;

  a_r6_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_pend |-> (wait_cnt <= 2'd1));
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  a_r7_no_mem_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pend && cpu_misal) |-> !cpu_gnt);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |=> cpu_err);
  a_r4_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_gnt && !eng_we) |=> eng_rvalid);
endmodule

// File: tb/shram_width_arb_tb_top.sv
`timescale 1ns/1ps
module shram_width_arb_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cfg_wide = 1'b0;
  logic cpu_cs = 0, cpu_rd = 0, cpu_wr = 0;
  logic [16:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, cpu_err;
  logic eng_req = 0, eng_we = 0;
  logic [7:0] eng_addr = '0, eng_be = '0;
  logic [63:0] eng_wdata = '0, eng_rdata;
  logic eng_gnt, eng_rvalid;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  shram_width_arb dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // processor access; lat = cycles from request to ready
  task automatic cpu_acc(input logic wr, input logic [16:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat, output logic again);
    cpu_cs = 1; cpu_wr = wr; cpu_rd = ~wr; cpu_addr = a; cpu_wdata = wd;
    lat = 0; rd = '0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); lat++;
      if (cpu_ready) break;
    end
    rd = cpu_rdata;
    cpu_cs = 0; cpu_wr = 0; cpu_rd = 0;
    @(negedge clk); again = cpu_ready;
  endtask

  // engine access; w = cycles waited before grant
  task automatic eng_acc(input logic we, input logic [7:0] a, input logic [63:0] wd,
                         input logic [7:0] be, output logic [63:0] rd, output int w);
    eng_req = 1; eng_we = we; eng_addr = a; eng_wdata = wd; eng_be = be; w = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (eng_gnt) break;
      @(negedge clk); w++;
    end
    @(negedge clk);
    eng_req = 0;
    rd = eng_rvalid ? eng_rdata : 64'hx;
  endtask

  function automatic logic [16:0] hwaddr(input int word, input int hw);
    return 17'((word << 2) | hw);
  endfunction

  task automatic t_reset;
    check("R1 ready", cpu_ready, 0);
    check("R1 err", cpu_err, 0);
    check("R1 gnt", eng_gnt, 0);
    check("R1 rvalid", eng_rvalid, 0);
    check("R1 rdata", cpu_rdata, 0);
  endtask

  task automatic t_wide;
    logic [63:0] r; logic [31:0] c; int l, w; logic ag;
    eng_acc(1, 8'd3, 64'h1111_2222_3333_4444, 8'hFF, r, w);
    cfg_wide = 1;
    cpu_acc(1, hwaddr(3, 2), 32'hDEAD_BEEF, c, l, ag);
    check("R6 latency idle", l, 1);
    check("R6 single pulse", ag, 0);
    eng_acc(0, 8'd3, 0, 0, r, w);
    check("R2 upper half only", r, 64'hDEAD_BEEF_3333_4444);
    cpu_acc(0, hwaddr(3, 0), 0, c, l, ag);
    check("R2 read low half", c, 32'h3333_4444);
    cpu_acc(0, hwaddr(3, 2), 0, c, l, ag);
    check("R2 read high half", c, 32'hDEAD_BEEF);
  endtask

  task automatic t_narrow;
    logic [63:0] r; logic [31:0] c; int l, w; logic ag;
    eng_acc(1, 8'd5, 64'hAAAA_BBBB_CCCC_DDDD, 8'hFF, r, w);
    cfg_wide = 0;
    cpu_acc(1, hwaddr(5, 1), 32'hFFFF_1234, c, l, ag);
    eng_acc(0, 8'd5, 0, 0, r, w);
    check("R3 halfword 1 only", r, 64'hAAAA_BBBB_1234_DDDD);
    cpu_acc(0, hwaddr(5, 3), 0, c, l, ag);
    check("R3 right-justified zero-extended", c, 32'h0000_AAAA);
    check("R7 aligned in 16-bit", cpu_err, 0);
  endtask

  task automatic t_engine_be;
    logic [63:0] r; int w;
    eng_acc(1, 8'd7, 64'h0, 8'hFF, r, w);
    eng_acc(1, 8'd7, 64'h8877_6655_4433_2211, 8'b1010_0101, r, w);
    eng_acc(0, 8'd7, 0, 0, r, w);
    check("R4 byte enables", r, 64'h8800_6600_0033_0011);
  endtask

  task automatic t_contend;
    logic [63:0] r; logic [31:0] c; int l, w; logic ag;
    cfg_wide = 1;
    eng_acc(1, 8'd9, 64'h0, 8'hFF, r, w);  // engine granted last
    fork
      cpu_acc(1, hwaddr(9, 0), 32'h0BAD_F00D, c, l, ag);
      eng_acc(1, 8'd9, 64'h5555_6666_0000_0000, 8'hF0, r, w);
    join
    check("R5 cpu wins tie after engine", l, 1);
    check("R5 engine waits one", w, 1);
    cpu_acc(1, hwaddr(10, 0), 32'h1, c, l, ag);  // cpu granted last
    fork
      cpu_acc(1, hwaddr(9, 2), 32'h7777_8888, c, l, ag);
      eng_acc(1, 8'd9, 64'h0000_0000_0000_00EE, 8'h01, r, w);
    join
    check("R5 engine wins tie after cpu", w, 0);
    check("R6 contended latency", l, 2);
    eng_acc(0, 8'd9, 0, 0, r, w);
    check("R5 both writes kept", r, 64'h7777_8888_0BAD_F0EE);
  endtask

  task automatic t_misal;
    logic [63:0] r; logic [31:0] c; int l, w; logic ag;
    cfg_wide = 1;
    eng_acc(1, 8'd12, 64'h0123_4567_89AB_CDEF, 8'hFF, r, w);
    check("R8 err low before", cpu_err, 0);
    cpu_acc(1, hwaddr(12, 1), 32'hFFFF_FFFF, c, l, ag);
    check("R7 ready still pulsed", l, 1);
    eng_acc(0, 8'd12, 0, 0, r, w);
    check("R7 write ignored", r, 64'h0123_4567_89AB_CDEF);
    cpu_acc(0, hwaddr(12, 3), 0, c, l, ag);
    check("R7 read returns zero", c, 0);
    check("R8 err set", cpu_err, 1);
    cpu_acc(0, hwaddr(12, 0), 0, c, l, ag);
    check("R2 aligned read after error", c, 32'h89AB_CDEF);
    check("R8 err sticky", cpu_err, 1);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_wide;
    t_narrow;
    t_engine_be;
    t_contend;
    t_misal;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule